// File: doc/BRIEF.md
# Gated Event Counter

This block is an up-counter that advances on the rising edge of a prescaled count clock. Counting can be qualified by an active-high gate. The gate comes either from a digital gate pin or from the output of an asynchronous comparator. The comparator level can optionally be latched on the falling edge of the count clock. The counter then always samples a gate level that has been stable for half a count-clock period, so a comparator transition that lands on a rising edge can neither drop an increment nor add one.

The block runs on a single system clock. The prescaled count clock is treated as a level that is synchronous to the system clock. Its rising and falling edges are turned into one-cycle strobes, and all state changes on those strobes. A one-byte configuration register, written and read through a simple write-strobe port, holds two fields. Bit 1 is the gate source select: 1 selects the gate pin and 0 selects the comparator. Bit 0 enables synchronization: 1 latches the comparator and 0 passes it straight through. The register resets to 0x02. The counter runs only while the enable input is high, and the gate acts only while the gate-enable input is high.

Top module: `gated_event_counter`

## Requirements
- R1: After reset the count output is 0x0000 and the configuration register reads 0x02, which selects the pin gate with synchronization off.
- R2: A write stores data bits 1 (gate source select) and 0 (synchronization enable). Data bits 7 to 2 are ignored and always read back as 0.
- R3: With the enable input high and the gate-enable input low, the count rises by exactly one on every count-clock rising edge, whatever the gate pin and comparator levels are.
- R4: With the enable input low, the count never changes, whatever the count clock and gate inputs do.
- R5: With gating on and bit 1 equal to 1, the count rises at a count-clock rising edge only if the gate pin is 1 at that edge.
- R6: With gating on, bit 1 equal to 0 and bit 0 equal to 0, the count rises at a rising edge only if the comparator input is 1 at that edge.
- R7: With gating on, bit 1 equal to 0 and bit 0 equal to 1, the comparator is latched at each count-clock falling edge. A rising edge counts only if the latched level is 1. A comparator change at a rising edge therefore has no effect until the next falling edge.
- R8: The count wraps from 0xFFFF to 0x0000.
- R9: Writing the configuration register never changes the count. The new setting applies from the next count-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Configuration read data |
| cnt_clk | input | 1 | Prescaled count clock, synchronous to clk |
| tmr_on | input | 1 | Counter enable |
| gate_en | input | 1 | Gate qualification enable |
| gate_pin | input | 1 | External gate level |
| cmp_in | input | 1 | Comparator output level |
| count | output | 16 | Counter value |

## Verification
Assertions check on every cycle that the count holds between rising edges and holds while disabled. They also check that it steps by exactly one when free-running, that it holds when the pin gate is low, that the latched comparator moves only on falling edges, and that register reads return only the two implemented bits. Whether no increment is lost or duplicated when the comparator toggles right on a rising edge can only be shown by the bench. It does this by comparing the count against a reference that tracks the latched level. The bench scenarios also cover the wrap at full scale and the effect of configuration changes in the middle of counting.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
   localparam int SEL_BIT  = 1;
   localparam int SYNC_BIT = 0;

   typedef struct packed {
      logic sel_pin;
      logic sync_en;
   } gcnt_cfg_t;
endpackage

// File: rtl/gcnt_cfg_reg.sv
module gcnt_cfg_reg
   import gcnt_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int HAS_SYNC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output gcnt_cfg_t        cfg
);
   localparam int PAD_W = REG_W - 2;

   if (REG_W < 2) begin : g_bad_reg_w
      $error("gcnt_cfg_reg: REG_W must hold two fields");
   end

   logic sel_q;
   logic sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sel_q <= 1'b1;
      else if (we) sel_q <= wdata[SEL_BIT];
   end

   if (HAS_SYNC != 0) begin : g_sync_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  sync_q <= 1'b0;
         else if (we) sync_q <= wdata[SYNC_BIT];
      end
   end else begin : g_no_sync_bit
      assign sync_q = 1'b0;
   end

   logic unused_hi;
   assign unused_hi = ^wdata[REG_W-1:2] ^ ((HAS_SYNC != 0) ? 1'b0 : wdata[SYNC_BIT]);

   assign cfg.sel_pin = sel_q;
   assign cfg.sync_en = sync_q;
   assign rdata       = {{PAD_W{1'b0}}, sel_q, sync_q};

   AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rdata == {{PAD_W{1'b0}}, $past(wdata[SEL_BIT]),
                       (HAS_SYNC != 0) ? $past(wdata[SYNC_BIT]) : 1'b0}); // R2
endmodule

// File: rtl/gcnt_edge_det.sv
module gcnt_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic cnt_clk,
   output logic rise,
   output logic fall
);
   logic cnt_clk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_clk_q <= 1'b0;
      else        cnt_clk_q <= cnt_clk;
   end

   assign rise = cnt_clk & ~cnt_clk_q;
   assign fall = ~cnt_clk & cnt_clk_q;
endmodule

// File: rtl/gcnt_gate_sel.sv
module gcnt_gate_sel
   import gcnt_pkg::*;
#(
   parameter int HAS_SYNC = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      fall,
   input  gcnt_cfg_t cfg,
   input  logic      gate_pin,
   input  logic      cmp_in,
   output logic      gate
);
   logic cmp_eff;

   if (HAS_SYNC != 0) begin : g_sync
      logic cmp_lat_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cmp_lat_q <= 1'b0;
         else if (fall) cmp_lat_q <= cmp_in;
      end

      assign cmp_eff = cfg.sync_en ? cmp_lat_q : cmp_in;

      AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !fall |=> $stable(cmp_lat_q)); // R7
      AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         fall |=> cmp_lat_q == $past(cmp_in)); // R7
   end else begin : g_async
      logic unused_sync;
      assign unused_sync = fall ^ cfg.sync_en ^ clk ^ rst_n;
      assign cmp_eff     = cmp_in;
   end

   assign gate = cfg.sel_pin ? gate_pin : cmp_eff;
endmodule

// File: rtl/gcnt_counter.sv
module gcnt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count_q <= '0;
      else if (step) count_q <= count_q + ONE;
   end

   assign count = count_q;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> count_q == $past(count_q) + ONE); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(count_q)); // R9
endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter
   import gcnt_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int REG_W    = 8,
   parameter int HAS_SYNC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             cnt_clk,
   input  logic             tmr_on,
   input  logic             gate_en,
   input  logic             gate_pin,
   input  logic             cmp_in,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
      $error("gated_event_counter: CNT_W out of range");
   end
   if (HAS_SYNC != 0 && HAS_SYNC != 1) begin : g_bad_sync
      $error("gated_event_counter: HAS_SYNC must be 0 or 1");
   end

   gcnt_cfg_t cfg;
   logic      rise;
   logic      fall;
   logic      gate;
   logic      step;

   gcnt_cfg_reg #(.REG_W(REG_W), .HAS_SYNC(HAS_SYNC)) cfg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .cfg   (cfg)
   );

   gcnt_edge_det edge_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_clk (cnt_clk),
      .rise    (rise),
      .fall    (fall)
   );

   gcnt_gate_sel #(.HAS_SYNC(HAS_SYNC)) gate_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall     (fall),
      .cfg      (cfg),
      .gate_pin (gate_pin),
      .cmp_in   (cmp_in),
      .gate     (gate)
   );

   assign step = rise & tmr_on & (~gate_en | gate);

   gcnt_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .count (count)
   );

   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_on |=> $stable(count)); // R4
   AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_on && !gate_en && rise) |=> count == $past(count) + ONE); // R3
   AST_PIN_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && cfg.sel_pin && !gate_pin) |=> $stable(count)); // R5
   AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(count)); // R9
endmodule

// File: tb/gated_event_counter_tb_top.sv
module gated_event_counter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        cnt_clk = 1'b0;
   logic        tmr_on = 1'b0;
   logic        gate_en = 1'b0;
   logic        gate_pin = 1'b0;
   logic        cmp_in = 1'b0;
   logic [15:0] count;

   int          n_chk = 0;
   int          n_fail = 0;
   logic [15:0] exp_cnt = 16'h0000;
   logic        sh_sel = 1'b1;
   logic        sh_sync = 1'b0;
   logic        cmp_lat_m = 1'b0;
   logic [15:0] exp_q[$];
   string       req_q[$];

   always #4 clk = ~clk;

   gated_event_counter dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cnt_clk(cnt_clk), .tmr_on(tmr_on),
      .gate_en(gate_en), .gate_pin(gate_pin), .cmp_in(cmp_in), .count(count)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   // monitor: pops one expected count per design cycle that follows a push
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) chk(req_q.pop_front(), count, exp_q.pop_front());
      end
   end

   task automatic wr_cfg(input logic [7:0] v);
      @(negedge clk);
      reg_we = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
      sh_sel = v[1];
      sh_sync = v[0];
   endtask

   // driver: one count-clock period, pushes expected count after each edge
   task automatic tick(input logic pin, input logic cmp, input string req);
      logic g;
      @(negedge clk);
      cnt_clk = 1'b1;
      gate_pin = pin;
      cmp_in = cmp;
      g = sh_sel ? pin : (sh_sync ? cmp_lat_m : cmp);
      if (tmr_on && (!gate_en || g)) exp_cnt = exp_cnt + 16'd1;
      exp_q.push_back(exp_cnt);
      req_q.push_back(req);
      @(negedge clk);
      cnt_clk = 1'b0;
      cmp_lat_m = cmp_in;
      exp_q.push_back(exp_cnt);
      req_q.push_back(req);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] start;
      int          ref_cnt;
      logic        prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 count", count, 16'h0000);
      chk("R1 cfg", {8'h00, reg_rdata}, 16'h0002);

      wr_cfg(8'hFF);
      chk("R2 upper bits ignored", {8'h00, reg_rdata}, 16'h0003);
      wr_cfg(8'hFC);
      chk("R2 upper bits read zero", {8'h00, reg_rdata}, 16'h0000);
      wr_cfg(8'h02);

      // R3: free running, gate inputs irrelevant
      @(negedge clk); tmr_on = 1'b1; gate_en = 1'b0;
      for (int i = 0; i < 20; i++) tick(i[0], i[1], "R3");
      chk("R3 total", count, 16'd20);

      // R4: disabled
      @(negedge clk); tmr_on = 1'b0;
      for (int i = 0; i < 10; i++) tick(1'b1, 1'b1, "R4");
      chk("R4 total", count, 16'd20);

      // R5: pin gate
      @(negedge clk); tmr_on = 1'b1; gate_en = 1'b1;
      for (int i = 0; i < 16; i++) tick(i[0] ^ i[2], 1'b1, "R5");
      chk("R5 total", count, 16'd28);

      // R6: asynchronous comparator, toggled at rising edges
      start = exp_cnt;
      wr_cfg(8'h00);
      chk("R9 count kept after write", count, start);
      for (int i = 0; i < 16; i++) tick(1'b0, i[1], "R6");
      chk("R6 total", count, start + 16'd8);

      // R7: synchronized comparator, toggled at rising edges
      start = exp_cnt;
      wr_cfg(8'h01);
      chk("R9 count kept after sync on", count, start);
      ref_cnt = 0;
      prev = cmp_lat_m;
      for (int i = 0; i < 24; i++) begin
         if (prev) ref_cnt++;
         tick(1'b1, i[0] ^ i[3], "R7");
         prev = i[0] ^ i[3];
      end
      chk("R7 reference count", count, start + 16'(ref_cnt));

      // R8: wrap through full scale while free running
      @(negedge clk); gate_en = 1'b0;
      begin
         int n;
         n = 65536 - int'(exp_cnt);
         for (int i = 0; i < n; i++) tick(1'b0, 1'b0, "R8");
      end
      chk("R8 wrap", count, 16'h0000);
      tick(1'b0, 1'b0, "R8");
      chk("R8 after wrap", count, 16'h0001);

      repeat (3) @(posedge clk);
      #1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule